// File: doc/BRIEF.md
# Interrupt Acknowledge Daisy-Chain Responder

This block is the responding half of a byte-wide interrupter on a VME backplane. It watches the address strobe, the acknowledge qualifier, the incoming daisy-chain line, the data strobes and the three level lines A3..A1. All of these arrive already synchronised to the local clock, except for one raw copy of the address strobe. The interrupt requester next to it supplies a pending flag, the programmed level and the 8-bit status/ID vector.

When an acknowledge cycle reaches this slot and this slot's request matches the level on the bus, the block latches the vector and drives it on D7..D0. It asserts DTACK once DS0 falls and tells the requester, with a one-cycle pulse, that the request was taken. In every other acknowledge cycle, including one where nothing is pending, it passes the daisy-chain grant to the next slot by pulling its outgoing line low. That line is released as soon as the raw address strobe rises. Every output returns to its released state once the sampled address strobe is high again.

Top module: `iack_responder`

## Requirements
- R1: After reset, dtack_n and iackout_n are 1, data_oe is 0, data_o is 0 and ack_o is 0.
- R2: An acknowledge cycle starts only when as_n goes from 1 to 0 while iack_n is 0. If iack_n is 1 at that falling edge, no output changes for the rest of that cycle, even when iackin_n falls.
- R3: In an acknowledge cycle, the first clock that sees iackin_n at 0 decides the outcome. If irq_pending is 1 and lvl_addr (A3..A1, A3 in the MSB) equals irq_level, then from the next cycle data_oe is 1, data_o carries irq_vector, and iackout_n stays 1.
- R4: If that decision finds no pending request or a level mismatch, then from the next cycle iackout_n is 0 and data_oe stays 0.
- R5: If as_n returns to 1 before iackin_n falls, the acknowledge cycle is dropped. A later fall of iackin_n while as_n is 1 has no effect.
- R6: While the vector is driven, dtack_n falls on the cycle after ds_n[0] (DS0) is seen at 0. A low on ds_n[1] (DS1) alone does not assert DTACK.
- R7: Once asserted, dtack_n stays 0 until both bits of ds_n are 1. On the cycle after that, dtack_n is 1 and data_oe is 0.
- R8: ack_o is 1 for exactly one cycle per answered acknowledge cycle, in the first cycle that dtack_n is 0.
- R9: With RAW_RELEASE=1, iackout_n goes to 1 combinationally as soon as as_raw_n is 1, without waiting for the sampled as_n.
- R10: One clock after the sampled as_n is seen at 1, dtack_n and iackout_n are 1 and data_oe is 0.
- R11: The vector is captured at the decision. Changes on irq_vector after that do not alter data_o within the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| as_n | input | 1 | Synchronised address strobe, active low |
| as_raw_n | input | 1 | Unsampled address strobe, active low |
| iack_n | input | 1 | Synchronised acknowledge qualifier, active low |
| iackin_n | input | 1 | Synchronised incoming daisy-chain grant, active low |
| ds_n | input | 2 | Synchronised data strobes {DS1, DS0}, active low |
| lvl_addr | input | LVL_W | Level on A3..A1 |
| irq_pending | input | 1 | Request outstanding from the requester |
| irq_level | input | LVL_W | Programmed interrupt level |
| irq_vector | input | VEC_W | Programmed status/ID vector |
| iackout_n | output | 1 | Outgoing daisy-chain grant, active low |
| dtack_n | output | 1 | Data acknowledge, active low |
| data_o | output | VEC_W | Vector for D7..D0 |
| data_oe | output | 1 | Data bus drive enable |
| ack_o | output | 1 | One-cycle pulse: request acknowledged |

## Verification
The bench builds the block with its default parameters: a 3-bit level, an 8-bit vector and RAW_RELEASE=1. With these, random draws cover all eight level codes on both the programmed side and the address side. They also cover the pending and idle cases and the path that releases the outgoing grant early from the raw strobe. Directed cases add an abandoned cycle, a non-acknowledge cycle, a strobe sequence that starts with DS1 only, and a vector change made after the capture.

// File: rtl/iack_pkg.sv
package iack_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_WAIT_IN,
      ST_PASS,
      ST_DRIVE,
      ST_DTACK,
      ST_DONE
   } iack_state_e;
endpackage

// File: rtl/iack_as_edge.sv
module iack_as_edge (
   input  logic clk,
   input  logic rst_n,
   input  logic as_n,
   output logic fall
);
   logic as_prev_q;

   always_ff @(posedge clk) begin
      if (!rst_n) as_prev_q <= 1'b1;
      else        as_prev_q <= as_n;
   end

   assign fall = as_prev_q & ~as_n;
endmodule

// File: rtl/iack_lvl_match.sv
module iack_lvl_match #(
   parameter int LVL_W = 3
) (
   input  logic             pending,
   input  logic [LVL_W-1:0] level,
   input  logic [LVL_W-1:0] addr_lvl,
   output logic             match
);
   assign match = pending && (level == addr_lvl);
endmodule

// File: rtl/iack_out_gate.sv
module iack_out_gate #(
   parameter bit RAW_RELEASE = 1'b1
) (
   input  logic pass_q_n,
   input  logic as_raw_n,
   output logic iackout_n
);
   generate
      if (RAW_RELEASE) begin : g_raw
         assign iackout_n = pass_q_n | as_raw_n;
      end else begin : g_reg
         logic unused_raw;
         assign unused_raw = as_raw_n;
         assign iackout_n  = pass_q_n;
      end
   endgenerate
endmodule

// File: rtl/iack_responder.sv
module iack_responder #(
   parameter int LVL_W       = 3,
   parameter int VEC_W       = 8,
   parameter bit RAW_RELEASE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             as_n,
   input  logic             as_raw_n,
   input  logic             iack_n,
   input  logic             iackin_n,
   input  logic [1:0]       ds_n,
   input  logic [LVL_W-1:0] lvl_addr,
   input  logic             irq_pending,
   input  logic [LVL_W-1:0] irq_level,
   input  logic [VEC_W-1:0] irq_vector,
   output logic             iackout_n,
   output logic             dtack_n,
   output logic [VEC_W-1:0] data_o,
   output logic             data_oe,
   output logic             ack_o
);
   import iack_pkg::*;

   localparam logic [1:0] DS_IDLE = 2'b11;

   initial begin
      assert_param_vec_w : assert (VEC_W == 8)
         else $error("byte-wide interrupter needs VEC_W == 8");
      assert_param_lvl_w : assert (LVL_W == 3)
         else $error("three level lines need LVL_W == 3");
   end

   iack_state_e      state_q, state_d;
   logic             as_fall, lvl_ok;
   logic [VEC_W-1:0] vec_q;
   logic             ack_q;
   logic             pass_q_n;

   iack_as_edge i_edge (
      .clk  (clk),
      .rst_n(rst_n),
      .as_n (as_n),
      .fall (as_fall)
   );

   iack_lvl_match #(.LVL_W(LVL_W)) i_match (
      .pending (irq_pending),
      .level   (irq_level),
      .addr_lvl(lvl_addr),
      .match   (lvl_ok)
   );

   always_comb begin
      state_d = state_q;
      if (state_q == ST_IDLE) begin
         if (as_fall && !iack_n) state_d = ST_WAIT_IN;
      end else if (as_n) begin
         state_d = ST_IDLE;
      end else begin
         unique case (state_q)
            ST_WAIT_IN: if (!iackin_n) state_d = lvl_ok ? ST_DRIVE : ST_PASS;
            ST_DRIVE:   if (!ds_n[0]) state_d = ST_DTACK;
            ST_DTACK:   if (ds_n == DS_IDLE) state_d = ST_DONE;
            default:    state_d = state_q;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         vec_q   <= '0;
         ack_q   <= 1'b0;
      end else begin
         state_q <= state_d;
         ack_q   <= (state_q == ST_DRIVE) && (state_d == ST_DTACK);
         if (state_q == ST_WAIT_IN && state_d == ST_DRIVE) vec_q <= irq_vector;
      end
   end

   assign pass_q_n = (state_q != ST_PASS);
   assign dtack_n  = (state_q != ST_DTACK);
   assign data_oe  = (state_q == ST_DRIVE) || (state_q == ST_DTACK);
   assign data_o   = data_oe ? vec_q : '0;
   assign ack_o    = ack_q;

   iack_out_gate #(.RAW_RELEASE(RAW_RELEASE)) i_gate (
      .pass_q_n (pass_q_n),
      .as_raw_n (as_raw_n),
      .iackout_n(iackout_n)
   );

   // R10: sampled strobe high releases everything one clock later
   assert_released_R10 : assert property (@(posedge clk) disable iff (!rst_n)
      as_n |=> (dtack_n && pass_q_n && !data_oe));
   // R8: acknowledge is a single-cycle pulse
   assert_one_pulse_R8 : assert property (@(posedge clk) disable iff (!rst_n)
      ack_o |=> !ack_o);
   // R6: DTACK only follows DS0
   assert_dtack_ds0_R6 : assert property (@(posedge clk) disable iff (!rst_n)
      $fell(dtack_n) |-> $past(!ds_n[0]));
   // R7: DTACK holds while a strobe is still low
   assert_dtack_hold_R7 : assert property (@(posedge clk) disable iff (!rst_n)
      (!dtack_n && !as_n && ds_n != DS_IDLE) |=> !dtack_n);
   // R3: driving starts only after a matching pending request
   assert_resp_match_R3 : assert property (@(posedge clk) disable iff (!rst_n)
      $rose(data_oe) |-> $past(irq_pending && (irq_level == lvl_addr) && !iackin_n));
   // R4: passing the grant only after IACKIN was seen low
   assert_pass_after_in_R4 : assert property (@(posedge clk) disable iff (!rst_n)
      $fell(pass_q_n) |-> $past(!iackin_n));
endmodule

// File: tb/test_iack_responder.sv
module test_iack_responder;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       as_n = 1'b1, as_raw_n = 1'b1, iack_n = 1'b1, iackin_n = 1'b1;
   logic [1:0] ds_n = 2'b11;
   logic [2:0] lvl_addr = '0, irq_level = '0;
   logic       irq_pending = 1'b0;
   logic [7:0] irq_vector = '0;
   logic       iackout_n, dtack_n, data_oe, ack_o;
   logic [7:0] data_o;

   int n_chk = 0, n_bad = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   iack_responder i_iack_responder (
      .clk(clk), .rst_n(rst_n), .as_n(as_n), .as_raw_n(as_raw_n),
      .iack_n(iack_n), .iackin_n(iackin_n), .ds_n(ds_n),
      .lvl_addr(lvl_addr), .irq_pending(irq_pending),
      .irq_level(irq_level), .irq_vector(irq_vector),
      .iackout_n(iackout_n), .dtack_n(dtack_n), .data_o(data_o),
      .data_oe(data_oe), .ack_o(ack_o)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic bit expect_resp(bit pend, logic [2:0] lvl, logic [2:0] adr);
      return pend && (lvl == adr);
   endfunction

   task automatic idle_check(input string req);
      check(dtack_n && iackout_n && !data_oe && !ack_o, req,
            {dtack_n, iackout_n, data_oe, ack_o}, 4'b1100);
   endtask

   task automatic end_cycle();
      as_raw_n = 1'b1; as_n = 1'b1; iack_n = 1'b1; iackin_n = 1'b1; ds_n = 2'b11;
      @(negedge clk);
      idle_check("R10");
      @(negedge clk);
   endtask

   task automatic run_iack(input bit pend, input logic [2:0] lvl,
                           input logic [2:0] adr, input logic [7:0] vec);
      bit resp = expect_resp(pend, lvl, adr);
      irq_pending = pend; irq_level = lvl; lvl_addr = adr; irq_vector = vec;
      iack_n = 1'b0; as_n = 1'b0; as_raw_n = 1'b0;
      @(negedge clk);
      idle_check("R2");
      iackin_n = 1'b0;
      @(negedge clk);
      if (resp) begin
         check(data_oe && data_o == vec && iackout_n, "R3", data_o, vec);
         irq_vector = ~vec;
         ds_n = 2'b10;
         @(negedge clk);
         check(!dtack_n && ack_o, "R6", {dtack_n, ack_o}, 2'b01);
         check(data_o == vec, "R11", data_o, vec);
         ds_n = 2'b00;
         @(negedge clk);
         check(!ack_o && !dtack_n, "R8", {ack_o, dtack_n}, 2'b00);
         ds_n = 2'b01;
         @(negedge clk);
         check(!dtack_n, "R7", dtack_n, 0);
         ds_n = 2'b11;
         @(negedge clk);
         check(dtack_n && !data_oe, "R7", {dtack_n, data_oe}, 2'b10);
      end else begin
         check(!iackout_n && !data_oe, "R4", {iackout_n, data_oe}, 2'b00);
         @(negedge clk);
         check(!iackout_n && dtack_n, "R4", {iackout_n, dtack_n}, 2'b01);
         as_raw_n = 1'b1;
         #1;
         check(iackout_n, "R9", iackout_n, 1);
      end
      end_cycle();
   endtask

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog actual=0 expected=1");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      int unsigned seed = 32'd1234;
      void'($urandom(seed));
      repeat (3) @(negedge clk);
      idle_check("R1");
      check(data_o == 8'h00, "R1", data_o, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // directed: match, mismatch, nothing pending
      run_iack(1'b1, 3'd5, 3'd5, 8'hA5);
      run_iack(1'b1, 3'd5, 3'd4, 8'h3C);
      run_iack(1'b0, 3'd2, 3'd2, 8'h11);

      // R5: abandoned before IACKIN
      iack_n = 1'b0; as_n = 1'b0; as_raw_n = 1'b0;
      irq_pending = 1'b1; irq_level = 3'd1; lvl_addr = 3'd1;
      @(negedge clk);
      as_n = 1'b1; as_raw_n = 1'b1;
      @(negedge clk);
      iackin_n = 1'b0;
      @(negedge clk);
      @(negedge clk);
      idle_check("R5");
      end_cycle();

      // R2: strobe falls with IACK high
      iack_n = 1'b1; as_n = 1'b0; as_raw_n = 1'b0;
      @(negedge clk);
      iackin_n = 1'b0;
      @(negedge clk);
      @(negedge clk);
      idle_check("R2");
      end_cycle();

      // R6: DS1 alone does not give DTACK
      irq_pending = 1'b1; irq_level = 3'd7; lvl_addr = 3'd7; irq_vector = 8'h5A;
      iack_n = 1'b0; as_n = 1'b0; as_raw_n = 1'b0;
      @(negedge clk);
      iackin_n = 1'b0;
      @(negedge clk);
      ds_n = 2'b01;
      @(negedge clk);
      @(negedge clk);
      check(dtack_n && data_oe, "R6", {dtack_n, data_oe}, 2'b11);
      ds_n = 2'b00;
      @(negedge clk);
      check(!dtack_n && ack_o, "R8", {dtack_n, ack_o}, 2'b01);
      end_cycle();

      // random mix
      for (int i = 0; i < 150; i++) begin
         bit         p = 1'($urandom);
         logic [2:0] l = 3'($urandom);
         logic [2:0] a = ($urandom % 2) ? l : 3'($urandom);
         run_iack(p, l, a, 8'($urandom));
      end

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule